// File: doc/BRIEF.md
# Compare-and-Branch Next-PC Unit

This unit picks the address of the next instruction for a 32-bit processor that keeps no condition flags. A conditional branch carries its own test: it compares two register values that the register file supplies and, when the test holds, redirects the program counter. Unconditional jumps always redirect. Both kinds come in a PC-relative form and a direct-address form, and each form has its own major opcode. Any other opcode, or a branch whose test fails, moves on to the next sequential word (PC+4, since memory is byte-addressed and each instruction is four bytes).

Each cycle the unit takes the current PC, the 5-bit major opcode, a 4-bit condition code, the two compared operands and the 27-bit displacement/target field. One clock edge later it presents the next PC, a taken flag, and a flag for an undefined condition code on a conditional branch. The result register is the unit's single pipeline stage.

Top module: `cbr_nextpc`

## Requirements
- R1: While reset is high and on the first cycle after it, next_pc_o is 0, taken_o is 0 and bad_cond_o is 0.
- R2: Any opcode other than 18 to 21 gives next_pc_o = pc_i + 4 with taken_o = 0 and bad_cond_o = 0 one clock edge after the inputs are applied. The condition code and operands have no effect.
- R3: Opcode 18 (relative jump) is always taken, with next_pc_o = pc_i + 4 + sign-extended field_i[26:0].
- R4: Opcode 19 (direct jump) is always taken, with next_pc_o = zero-extended field_i[26:0].
- R5: Opcode 20 (relative conditional branch), when its test holds, gives taken_o = 1 and next_pc_o = pc_i + 4 + sign-extended field_i[20:0].
- R6: Opcode 21 (direct conditional branch), when its test holds, gives taken_o = 1 and next_pc_o = zero-extended field_i[20:0].
- R7: Condition code 4'b0000 holds when opa_i equals opb_i. Code 4'b0001 holds when they differ.
- R8: Code 4'b0010 holds when opa_i < opb_i and code 4'b0011 holds when opa_i > opb_i, both as signed two's-complement values.
- R9: A conditional branch whose test fails gives next_pc_o = pc_i + 4 and taken_o = 0.
- R10: Condition codes 4'b0100 to 4'b1111 on opcode 20 or 21 are never taken (next_pc_o = pc_i + 4) and set bad_cond_o = 1. On any other opcode these codes leave bad_cond_o at 0.
- R11: For conditional branches, field_i[26:21] has no effect on the result.
- R12: The sequential address pc_i + 4 and the relative targets wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_i | input | 32 | Address of the current instruction |
| opcode_i | input | 5 | Major opcode |
| cond_i | input | 4 | Branch condition code |
| opa_i | input | 32 | First compared operand |
| opb_i | input | 32 | Second compared operand |
| field_i | input | 27 | Displacement or direct-target field |
| next_pc_o | output | 32 | Registered next program counter |
| taken_o | output | 1 | Registered redirect flag |
| bad_cond_o | output | 1 | Registered undefined-condition flag |

## Verification
Two functions meet in a single cycle: the undefined-condition check and the operand comparison. Operand pairs that would satisfy equal, less or greater are evaluated in the same cycle as an undefined code. The sweep therefore presents every condition code with every opcode over the same operand pairs, including pairs that differ only in signed and unsigned ordering. Each result is judged against an arithmetic model of the requirements: an undefined code on a conditional opcode must raise the flag and fall through to PC+4, whatever the comparison says. The same code on other opcodes must leave the flag low. The PC wrap point and fields with their sign bit or unused upper bits set are part of the sweep.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

    localparam int unsigned OPC_W = 5;
    localparam int unsigned CND_W = 4;

    localparam logic [OPC_W-1:0] OPC_JMP_REL = 5'd18;
    localparam logic [OPC_W-1:0] OPC_JMP_DIR = 5'd19;
    localparam logic [OPC_W-1:0] OPC_BR_REL  = 5'd20;
    localparam logic [OPC_W-1:0] OPC_BR_DIR  = 5'd21;

    typedef enum logic [CND_W-1:0] {
        TEST_EQ = 4'b0000,
        TEST_NE = 4'b0001,
        TEST_LT = 4'b0010,
        TEST_GT = 4'b0011
    } test_e;

    typedef enum logic [1:0] {
        KIND_SEQ  = 2'd0,
        KIND_JUMP = 2'd1,
        KIND_COND = 2'd2
    } kind_e;

    typedef struct packed {
        kind_e kind;
        logic  direct;
        logic  legal;
        test_e test;
    } dec_t;

    typedef struct packed {
        logic eq;
        logic lt;
        logic gt;
    } rel_t;

    function automatic logic code_is_legal(input logic [CND_W-1:0] c);
        return c[CND_W-1:2] == '0;
    endfunction

endpackage

// File: rtl/cbr_decode.sv
module cbr_decode
    import cbr_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    input  logic [CND_W-1:0] cond,
    output dec_t             dec
);
    always_comb begin
        dec.kind   = KIND_SEQ;
        dec.direct = 1'b0;
        dec.legal  = code_is_legal(cond);
        dec.test   = test_e'(cond);
        unique case (opcode)
            OPC_JMP_REL: begin dec.kind = KIND_JUMP; dec.direct = 1'b0; end
            OPC_JMP_DIR: begin dec.kind = KIND_JUMP; dec.direct = 1'b1; end
            OPC_BR_REL:  begin dec.kind = KIND_COND; dec.direct = 1'b0; end
            OPC_BR_DIR:  begin dec.kind = KIND_COND; dec.direct = 1'b1; end
            default:     begin dec.kind = KIND_SEQ;  dec.direct = 1'b0; end
        endcase
    end
endmodule

// File: rtl/cbr_compare.sv
module cbr_compare
    import cbr_pkg::*;
#(
    parameter int unsigned XLEN      = 32,
    parameter bit          SIGNED_OR = 1'b1
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output rel_t            rel
);
    logic less;

    generate
        if (SIGNED_OR) begin : g_signed
            assign less = $signed(a) < $signed(b);
        end else begin : g_unsigned
            assign less = a < b;
        end
    endgenerate

    always_comb begin
        rel.eq = (a == b);
        rel.lt = less;
        rel.gt = !less && (a != b);
    end
endmodule

// File: rtl/cbr_target.sv
module cbr_target #(
    parameter int unsigned XLEN   = 32,
    parameter int unsigned JDISPW = 27,
    parameter int unsigned BDISPW = 21
) (
    input  logic [XLEN-1:0]   pc,
    input  logic [JDISPW-1:0] field,
    output logic [XLEN-1:0]   seq_pc,
    output logic [XLEN-1:0]   jmp_rel,
    output logic [XLEN-1:0]   jmp_dir,
    output logic [XLEN-1:0]   br_rel,
    output logic [XLEN-1:0]   br_dir
);
    localparam int unsigned JPAD = XLEN - JDISPW;
    localparam int unsigned BPAD = XLEN - BDISPW;
    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    logic [XLEN-1:0] jsext;
    logic [XLEN-1:0] bsext;

    assign seq_pc  = pc + STEP;
    assign jsext   = {{JPAD{field[JDISPW-1]}}, field};
    assign bsext   = {{BPAD{field[BDISPW-1]}}, field[BDISPW-1:0]};
    assign jmp_rel = seq_pc + jsext;
    assign br_rel  = seq_pc + bsext;
    assign jmp_dir = {{JPAD{1'b0}}, field};
    assign br_dir  = {{BPAD{1'b0}}, field[BDISPW-1:0]};
endmodule

// File: rtl/cbr_nextpc.sv
module cbr_nextpc
    import cbr_pkg::*;
#(
    parameter int unsigned XLEN   = 32,
    parameter int unsigned JDISPW = 27,
    parameter int unsigned BDISPW = 21
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [XLEN-1:0]     pc_i,
    input  logic [OPC_W-1:0]    opcode_i,
    input  logic [CND_W-1:0]    cond_i,
    input  logic [XLEN-1:0]     opa_i,
    input  logic [XLEN-1:0]     opb_i,
    input  logic [JDISPW-1:0]   field_i,
    output logic [XLEN-1:0]     next_pc_o,
    output logic                taken_o,
    output logic                bad_cond_o
);
    dec_t            dec;
    rel_t            rel;
    logic [XLEN-1:0] seq_pc, jmp_rel, jmp_dir, br_rel, br_dir;
    logic            hit, take, bad;
    logic [XLEN-1:0] target, next_c;

    cbr_decode u_dec (
        .opcode (opcode_i),
        .cond   (cond_i),
        .dec    (dec)
    );

    cbr_compare #(.XLEN(XLEN), .SIGNED_OR(1'b1)) u_cmp (
        .a   (opa_i),
        .b   (opb_i),
        .rel (rel)
    );

    cbr_target #(.XLEN(XLEN), .JDISPW(JDISPW), .BDISPW(BDISPW)) u_tgt (
        .pc      (pc_i),
        .field   (field_i),
        .seq_pc  (seq_pc),
        .jmp_rel (jmp_rel),
        .jmp_dir (jmp_dir),
        .br_rel  (br_rel),
        .br_dir  (br_dir)
    );

    always_comb begin
        unique case (dec.test)
            TEST_EQ: hit = rel.eq;
            TEST_NE: hit = !rel.eq;
            TEST_LT: hit = rel.lt;
            TEST_GT: hit = rel.gt;
            default: hit = 1'b0;
        endcase
    end

    always_comb begin
        take   = 1'b0;
        bad    = 1'b0;
        target = seq_pc;
        unique case (dec.kind)
            KIND_JUMP: begin
                take   = 1'b1;
                target = dec.direct ? jmp_dir : jmp_rel;
            end
            KIND_COND: begin
                bad    = !dec.legal;
                take   = dec.legal && hit;
                target = dec.direct ? br_dir : br_rel;
            end
            default: begin
                take   = 1'b0;
                target = seq_pc;
            end
        endcase
        next_c = take ? target : seq_pc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            next_pc_o  <= '0;
            taken_o    <= 1'b0;
            bad_cond_o <= 1'b0;
        end else begin
            next_pc_o  <= next_c;
            taken_o    <= take;
            bad_cond_o <= bad;
        end
    end

    // R8
    cmp_one_rel_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({rel.eq, rel.lt, rel.gt}) == 1);

    // R10
    bad_never_taken_chk: assert property (@(posedge clk) disable iff (rst)
        bad_cond_o |-> !taken_o);

    // R9
    fallthrough_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && !taken_o) |-> (next_pc_o == $past(pc_i) + XLEN'(4)));

    // R3
    jump_taken_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && ($past(opcode_i) == OPC_JMP_REL || $past(opcode_i) == OPC_JMP_DIR))
        |-> (taken_o && !bad_cond_o));

    // R2
    seq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && ($past(opcode_i) < OPC_JMP_REL || $past(opcode_i) > OPC_BR_DIR))
        |-> (!taken_o && !bad_cond_o));
endmodule

// File: tb/cbr_nextpc_test.sv
`timescale 1ns/1ps
module cbr_nextpc_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pc_i = '0;
    logic [4:0]  opcode_i = '0;
    logic [3:0]  cond_i = '0;
    logic [31:0] opa_i = '0;
    logic [31:0] opb_i = '0;
    logic [26:0] field_i = '0;
    logic [31:0] next_pc_o;
    logic        taken_o;
    logic        bad_cond_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    cbr_nextpc uut (
        .clk(clk), .rst(rst), .pc_i(pc_i), .opcode_i(opcode_i), .cond_i(cond_i),
        .opa_i(opa_i), .opb_i(opb_i), .field_i(field_i),
        .next_pc_o(next_pc_o), .taken_o(taken_o), .bad_cond_o(bad_cond_o)
    );

    initial begin
        #3000000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    function automatic logic [31:0] pick_a(input int k);
        case (k)
            0: return 32'd5;          1: return 32'd5;
            2: return 32'd6;          3: return 32'hFFFF_FFFF;
            4: return 32'd1;          5: return 32'h8000_0000;
            6: return 32'h7FFF_FFFF;  default: return 32'd0;
        endcase
    endfunction

    function automatic logic [31:0] pick_b(input int k);
        case (k)
            0: return 32'd5;          1: return 32'd6;
            2: return 32'd5;          3: return 32'd1;
            4: return 32'hFFFF_FFFF;  5: return 32'h7FFF_FFFF;
            6: return 32'h8000_0000;  default: return 32'd0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] enp,
                         input logic et, input logic eb);
        n_cmp++;
        if (next_pc_o !== enp || taken_o !== et || bad_cond_o !== eb) begin
            n_bad++;
            $display("FAIL %s: op=%0d cond=%0d got pc=%h t=%b b=%b exp pc=%h t=%b b=%b",
                     tag, opcode_i, cond_i, next_pc_o, taken_o, bad_cond_o, enp, et, eb);
        end
    endtask

    initial begin
        logic [31:0] pcs [3];
        logic [26:0] flds [3];
        pcs[0] = 32'h0000_1000; pcs[1] = 32'hFFFF_FFFC; pcs[2] = 32'h0040_0100;
        flds[0] = 27'h000_0010; flds[1] = 27'h7FF_FFF0; flds[2] = 27'h540_1234;

        repeat (3) @(negedge clk);
        // R1: outputs held at zero during reset
        check("R1", 32'd0, 1'b0, 1'b0);
        pc_i = 32'h1234_5678; opcode_i = 5'd18;
        @(negedge clk);
        check("R1", 32'd0, 1'b0, 1'b0);
        rst = 1'b0;

        for (int p = 0; p < 3; p++) begin
            for (int f = 0; f < 3; f++) begin
                for (int k = 0; k < 8; k++) begin
                    for (int op = 0; op < 32; op++) begin
                        for (int c = 0; c < 16; c++) begin
                            logic [31:0] seq, enp, a, b;
                            logic        et, eb, hold;
                            string       tag;
                            a = pick_a(k); b = pick_b(k);
                            pc_i = pcs[p]; field_i = flds[f];
                            opcode_i = 5'(op); cond_i = 4'(c);
                            opa_i = a; opb_i = b;
                            @(negedge clk);
                            seq = pcs[p] + 32'd4;              // R12 wrap modulo 2^32
                            enp = seq; et = 1'b0; eb = 1'b0;
                            case (c)
                                0: hold = (a == b);                     // R7
                                1: hold = (a != b);                     // R7
                                2: hold = ($signed(a) < $signed(b));    // R8
                                3: hold = ($signed(a) > $signed(b));    // R8
                                default: hold = 1'b0;
                            endcase
                            if (op == 18) begin
                                tag = "R3"; et = 1'b1;
                                enp = seq + {{5{flds[f][26]}}, flds[f]};
                            end else if (op == 19) begin
                                tag = "R4"; et = 1'b1;
                                enp = {5'd0, flds[f]};
                            end else if (op == 20 || op == 21) begin
                                if (c > 3) begin
                                    tag = "R10"; eb = 1'b1;
                                end else if (hold) begin
                                    et = 1'b1;
                                    // R11: only field bits 20..0 form the target
                                    if (op == 20) begin
                                        tag = (c < 2) ? "R5 R7 R11" : "R5 R8 R11";
                                        enp = seq + {{11{flds[f][20]}}, flds[f][20:0]};
                                    end else begin
                                        tag = (c < 2) ? "R6 R7 R11" : "R6 R8 R11";
                                        enp = {11'd0, flds[f][20:0]};
                                    end
                                end else begin
                                    tag = (c < 2) ? "R9 R7" : "R9 R8";
                                end
                            end else begin
                                tag = (c > 3) ? "R2 R10" : "R2";
                            end
                            if (p == 1 && !et) tag = {tag, " R12"};
                            check(tag, enp, et, eb);
                        end
                    end
                end
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule